// File: doc/BRIEF.md
# Coded Receive Volume Attenuator

This block scales received voice samples in the digital receive path. Every incoming word carries a 13-bit two's-complement sample together with a 3-bit attenuation code. The block multiplies the sample by a gain picked by that code and rounds the product back to 13 bits. The result comes out one clock after the input strobe. The eight gains fall in 3 dB steps, from unity down to about -21 dB.

The code is applied to its own sample only and is never held in a register. A word that arrives without a code of its own cannot inherit the setting of the word before it. Strobes may come on every clock, and each sample is scaled with the code that arrived beside it. Between strobes the output sample holds its last value.

Top module: `rx_vol_scaler`

## Requirements
- R1: With code 000 (0 dB) the output sample equals the input sample bit for bit, for every 13-bit value.
- R2: For code k (k = 0..7, where code bit 2 is the first-received, most significant bit), the output is floor((x * G[k] + 16384) / 32768), with x the signed input and G = 32768, 23198, 16423, 11627, 8231, 5827, 4125, 2920.
- R3: The output never overflows: input -4096 at code 000 gives -4096, and the magnitude of the output never exceeds the magnitude of its input.
- R4: out_valid is high exactly in the clock after each clock in which in_valid is high, and low otherwise.
- R5: Strobes on consecutive clocks are all accepted, and each output uses only the code that came with its own sample; no code is carried over between words.
- R6: While rst_n is low, out_valid is 0 and out_sample is 0.
- R7: In a clock where in_valid is low, out_sample keeps its previous value, whatever in_sample and in_code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 13 | Received sample, two's complement |
| in_code | input | 3 | Attenuation code for this sample, 000 = 0 dB, 111 = -21 dB |
| out_valid | output | 1 | Scaled sample strobe, one clock after in_valid |
| out_sample | output | 13 | Scaled sample, two's complement |

## Verification
Two things can happen in the same clock: a new sample is accepted with a fresh code, and the previous word's scaled result appears at the output. Any carry-over of state between words would show up here. The bench provokes this with runs of strobes on consecutive clocks, in which the code changes at every word. Between these runs it inserts idle clocks with random junk on the sample and code inputs. Every output word is compared with a bench model of the rounded product for the code sent with that word alone, and the output is also checked to stay unchanged through each idle gap.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

   // Fractional bits of the gain constants (unity = 2**GAIN_FRAC).
   localparam int GAIN_FRAC = 15;
   // Stored gain width, wide enough to hold unity.
   localparam int GAIN_W    = GAIN_FRAC + 1;
   // Attenuation per step in dB, used only for documentation of the table.
   localparam int STEP_DB   = 3;

   // Gain for attenuation step k, approximating 10**(-STEP_DB*k/20) in Q1.15.
   function automatic logic [GAIN_W-1:0] step_gain(input int unsigned k);
      logic [GAIN_W-1:0] g;
      case (k)
         0:       g = 16'd32768;
         1:       g = 16'd23198;
         2:       g = 16'd16423;
         3:       g = 16'd11627;
         4:       g = 16'd8231;
         5:       g = 16'd5827;
         6:       g = 16'd4125;
         default: g = 16'd2920;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/rvs_gain_lut.sv
module rvs_gain_lut #(
   parameter int CODE_W = 3,
   parameter int GAIN_W = rvs_pkg::GAIN_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [GAIN_W-1:0] gain
);
   localparam int N_STEPS = 2 ** CODE_W;

   generate
      if (CODE_W != 3)
         $error("rvs_gain_lut: the step table is defined for a 3-bit code");
      if (GAIN_W != rvs_pkg::GAIN_W)
         $error("rvs_gain_lut: gain width must match the package constants");
   endgenerate

   logic [GAIN_W-1:0] table_q [N_STEPS];

   for (genvar s = 0; s < N_STEPS; s++) begin : g_step
      localparam logic [GAIN_W-1:0] STEP_G = rvs_pkg::step_gain(s);
      assign table_q[s] = STEP_G;
   end

   assign gain = table_q[code];

endmodule

// File: rtl/rvs_scale_mult.sv
module rvs_scale_mult #(
   parameter int SAMPLE_W  = 13,
   parameter int GAIN_W    = rvs_pkg::GAIN_W,
   parameter int FRAC_W    = rvs_pkg::GAIN_FRAC,
   parameter int MUL_STYLE = 0          // 0: direct product, 1: shift-add array
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic        [GAIN_W-1:0]   gain,
   output logic signed [SAMPLE_W-1:0] scaled
);
   localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
   localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC_W - 1);

   generate
      if (FRAC_W < 1 || FRAC_W >= GAIN_W + 1)
         $error("rvs_scale_mult: FRAC_W out of range");
      if (MUL_STYLE != 0 && MUL_STYLE != 1)
         $error("rvs_scale_mult: MUL_STYLE must be 0 or 1");
   endgenerate

   logic signed [PROD_W-1:0] sample_x;
   logic signed [PROD_W-1:0] product;
   logic signed [PROD_W-1:0] rounded;
   logic signed [PROD_W-1:0] shifted;

   assign sample_x = PROD_W'(sample);

   generate
      if (MUL_STYLE == 0) begin : g_direct
         logic signed [PROD_W-1:0] gain_x;
         assign gain_x  = PROD_W'(signed'({1'b0, gain}));
         assign product = sample_x * gain_x;
      end else begin : g_shift_add
         logic signed [PROD_W-1:0] partial [GAIN_W];
         for (genvar b = 0; b < GAIN_W; b++) begin : g_pp
            assign partial[b] = gain[b] ? (sample_x <<< b) : '0;
         end
         always_comb begin
            product = '0;
            for (int b = 0; b < GAIN_W; b++) product = product + partial[b];
         end
      end
   endgenerate

   // Round half up, then drop the fraction.
   assign rounded = product + HALF_LSB;
   assign shifted = rounded >>> FRAC_W;
   assign scaled  = shifted[SAMPLE_W-1:0];

   // R3: bits above the output width must be pure sign extension.
   always_comb begin
      a_r3_no_overflow : assert (&shifted[PROD_W-1:SAMPLE_W-1] || ~|shifted[PROD_W-1:SAMPLE_W-1])
         else $error("scaled result does not fit the sample width");
   end

endmodule

// File: rtl/rx_vol_scaler.sv
module rx_vol_scaler #(
   parameter int SAMPLE_W  = 13,
   parameter int CODE_W    = 3,
   parameter int MUL_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic [CODE_W-1:0]   in_code,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample
);
   localparam int GAIN_W = rvs_pkg::GAIN_W;
   localparam int FRAC_W = rvs_pkg::GAIN_FRAC;

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 24)
         $error("rx_vol_scaler: SAMPLE_W out of range");
   endgenerate

   logic [GAIN_W-1:0]          gain_sel;
   logic signed [SAMPLE_W-1:0] scaled;

   rvs_gain_lut #(
      .CODE_W (CODE_W),
      .GAIN_W (GAIN_W)
   ) u_lut (
      .code (in_code),
      .gain (gain_sel)
   );

   rvs_scale_mult #(
      .SAMPLE_W  (SAMPLE_W),
      .GAIN_W    (GAIN_W),
      .FRAC_W    (FRAC_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_mult (
      .sample (signed'(in_sample)),
      .gain   (gain_sel),
      .scaled (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= scaled;
      end
   end

   function automatic int magn(input logic [SAMPLE_W-1:0] v);
      int s;
      s = int'(signed'(v));
      return (s < 0) ? -s : s;
   endfunction

   a_r4_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r4_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r7_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample));
   a_r1_unity_exact : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_code == '0) |=> out_sample == $past(in_sample));
   a_r3_magnitude : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> magn(out_sample) <= magn($past(in_sample)));

endmodule

// File: tb/rx_vol_scaler_bench.sv
module rx_vol_scaler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [12:0] in_sample = '0;
   logic [2:0]  in_code = '0;
   logic        out_valid;
   logic [12:0] out_sample;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // expected outputs for the cycle after the current drive
   logic        exp_valid = 1'b0;
   logic [12:0] exp_data  = '0;
   string       exp_tag   = "R6";

   always #2.5 clk = ~clk;

   rx_vol_scaler u_rx_vol_scaler (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .in_sample (in_sample), .in_code (in_code),
      .out_valid (out_valid), .out_sample (out_sample));

   function automatic int gain_of(input int k);
      case (k)
         0: return 32768; 1: return 23198; 2: return 16423; 3: return 11627;
         4: return 8231;  5: return 5827;  6: return 4125;  default: return 2920;
      endcase
   endfunction

   function automatic logic [12:0] model(input logic [12:0] x, input logic [2:0] k);
      longint p;
      p = longint'(signed'(x)) * longint'(gain_of(int'(k)));
      p = (p + 64'sd16384) >>> 15;
      return p[12:0];
   endfunction

   task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag,
                  signed'(act), signed'(exp));
      end
   endtask

   // Check the outputs of the previous drive, then drive the next input.
   task automatic step(input logic v, input logic [12:0] x, input logic [2:0] k,
                       input string tag);
      @(negedge clk);
      check("R4 valid", {12'd0, out_valid}, {12'd0, exp_valid});
      check(exp_tag, out_sample, exp_data);
      in_valid  = v;
      in_sample = x;
      in_code   = k;
      exp_valid = v;
      if (v) begin
         exp_data = model(x, k);
         exp_tag  = tag;
      end else begin
         exp_tag = "R7";
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R6: reset state
      check("R6 valid", {12'd0, out_valid}, 13'd0);
      check("R6 data", out_sample, 13'd0);
      rst_n = 1'b1;
      // R3: most negative value at 0 dB
      step(1, 13'h1000, 3'd0, "R3");
      step(1, 13'h1000, 3'd0, "R1");
      // R1: passthrough of extremes
      step(1, 13'h0FFF, 3'd0, "R1");
      step(1, 13'h1FFF, 3'd0, "R1");
      // R2: every code on the largest positive and negative values
      for (int k = 0; k < 8; k++) step(1, 13'h0FFF, 3'(k), "R2");
      for (int k = 0; k < 8; k++) step(1, 13'h1000, 3'(k), "R2");
      // R2: rounding of small values, -1 at -21 dB gives 0
      step(1, 13'h1FFF, 3'd7, "R2");
      step(1, 13'd1, 3'd1, "R2");
      step(1, 13'd6, 3'd4, "R2");
      // R7: idle with junk on inputs
      step(0, 13'h0ABC, 3'd5, "R7");
      step(0, 13'h1234, 3'd2, "R7");
      // R5: back-to-back with alternating codes
      for (int i = 0; i < 16; i++) step(1, 13'd3000 - 13'(i * 377), 3'(i % 2 ? 7 : 0), "R5");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic v;
         logic [12:0] x;
         logic [2:0] k;
         v = ($urandom % 10) < 7;
         x = 13'($urandom);
         k = 3'($urandom);
         step(v, x, k, (k == 0) ? "R1" : "R5");
      end
      step(0, '0, '0, "R7");
      step(0, '0, '0, "R7");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule